// File: doc/BRIEF.md
# Vector Condition-Field Fail-First Sequencer

This block walks a vector of 4-bit condition fields, one element per clock, and applies a single condition operation to each element. The operation is either a single-bit logic function (AND, OR, NOR), which rewrites one bit of the destination field, or a whole-field move. A one-cycle `go` pulse starts a run. The caller supplies the vector length, the operand indices, a predicate mask and a set of mode flags. The block drives read and write ports of an external condition-field register file. Reads from that file are combinational.

Per-element predication either skips a masked element or writes a fill value into its destination field. In early-exit mode, one bit of each written result is tested: the destination bit for bit operations, or a selectable bit for moves. The first element that fails the test ends the run. The block reports the surviving length together with a one-cycle done pulse. Elements can run in ascending or descending order. A failing element can be counted into the reported length or left out of it.

Top module: `cf_failfirst_seq`

## Requirements
- R1: After a synchronous reset, `fin`, `rf_we` and `res_len` are all 0.
- R2: An accepted `go` with `vlen`>0 visits one element per clock. Element e uses fields (idx>>2)+e modulo the field count for `dst_idx`, `srca_idx` and `srcb_idx`. The bit position idx[1:0] stays fixed. The write for the k-th visited element appears on the write port k+1 cycles after the accepting edge.
- R3: With `rev_order`=1, elements are visited from `vlen`-1 down to 0. Otherwise they run from 0 up to `vlen`-1.
- R4: `opsel` 0/1/2 sets the destination bit to A AND B, A OR B or NOR(A,B) and keeps the other three destination bits. `opsel` 3 copies source field A into the destination field.
- R5: If `zero_en`=1 and `pmask[e]`=0, the whole destination field is written with 4'h0. When `ones_fill`=1 it is written with 4'hF instead.
- R6: If `zero_en`=0 and `pmask[e]`=0, element e is not written and is not tested.
- R7: With `ff_en`=1, the tested bit of each written value is checked. For `opsel` 0..2 the tested bit is `dst_idx`[1:0]; for `opsel` 3 it is `test_sel`. The test passes when the bit XOR `test_inv` is 1. The first failing element is still written, and no later element is written.
- R8: `res_len` is `vlen` when no test fails. On a failure it is the number of elements visited before the failing one plus `len_incl`. `fin` pulses for one cycle on the edge that writes the last element.
- R9: `go` with `vlen`=0 gives `fin`=1 and `res_len`=0 after the next edge, with no writes.
- R10: `go` while a run is in progress is ignored.
- R11: An element that reads a field written by the element just before it sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted when idle |
| vlen | input | 7 | Vector length, 0..64 |
| opsel | input | 2 | 0 AND, 1 OR, 2 NOR, 3 field move |
| dst_idx | input | 9 | Destination field (bits 8:2) and bit (1:0) |
| srca_idx | input | 9 | Source A field and bit |
| srcb_idx | input | 9 | Source B field and bit |
| pmask | input | 64 | Predicate bit per element number |
| zero_en | input | 1 | Fill masked elements instead of skipping |
| ones_fill | input | 1 | Fill value all ones instead of zeros |
| ff_en | input | 1 | Early-exit test enable |
| rev_order | input | 1 | Descending element order |
| len_incl | input | 1 | Count the failing element into the length |
| test_inv | input | 1 | Pass on a clear bit |
| test_sel | input | 2 | Tested bit for field moves |
| rf_a_addr | output | 7 | Source A field read address |
| rf_b_addr | output | 7 | Source B field read address |
| rf_d_addr | output | 7 | Destination field read address |
| rf_a_data | input | 4 | Source A field data |
| rf_b_data | input | 4 | Source B field data |
| rf_d_data | input | 4 | Destination field data |
| rf_we | output | 1 | Field write enable |
| rf_waddr | output | 7 | Field write address |
| rf_wdata | output | 4 | Field write data |
| fin | output | 1 | Done pulse |
| res_len | output | 7 | Final, possibly truncated, length |

## Verification
A wrong step count or wrong element order shows up one cycle later as a wrong address on the write port. A bad forwarding decision shows up as a wrong data value on the next write of a chained run. A wrong predicate or early-exit decision shows up in two ways: a write that should not happen or a missing write, both within one cycle, and a wrong `res_len` or a mistimed `fin` when the run ends. Each write is compared in order against a model that keeps its own copy of the register file, so any divergence is reported at the element where it happens.

// File: rtl/cffs_pkg.sv
package cffs_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_NOR  = 2'd2,
    OP_MOVE = 2'd3
  } cf_op_e;

  localparam int CF_W = 4;

  function automatic logic bit_fn(input cf_op_e op, input logic a, input logic b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_NOR:  return ~(a | b);
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/cffs_order.sv
module cffs_order #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic           rev,
  input  logic [VLW-1:0] vl,
  output logic [VLW-1:0] step,
  output logic [VLW-1:0] elem,
  output logic           last
);
  always_ff @(posedge clk) begin
    if (rst)       step <= '0;
    else if (load) step <= '0;
    else if (adv)  step <= step + VLW'(1);
  end

  assign elem = rev ? (vl - VLW'(1) - step) : step;
  assign last = (step == vl - VLW'(1));

  // R2: the step counter never runs past the captured length
  a_r2_step_in_range: assert property (@(posedge clk) disable iff (rst)
    adv |-> (step < vl));
endmodule

// File: rtl/cffs_elem.sv
module cffs_elem
  import cffs_pkg::*;
(
  input  cf_op_e          op,
  input  logic            pbit,
  input  logic            zero_en,
  input  logic            ones_fill,
  input  logic [CF_W-1:0] a_f,
  input  logic [CF_W-1:0] b_f,
  input  logic [CF_W-1:0] d_f,
  input  logic [1:0]      a_b,
  input  logic [1:0]      b_b,
  input  logic [1:0]      d_b,
  output logic            wr,
  output logic [CF_W-1:0] val
);
  logic r;

  always_comb begin
    r   = bit_fn(op, a_f[a_b], b_f[b_b]);
    wr  = 1'b1;
    val = d_f;
    if (!pbit) begin
      wr  = zero_en;
      val = ones_fill ? {CF_W{1'b1}} : '0;
    end else if (op == OP_MOVE) begin
      val = a_f;
    end else begin
      val[d_b] = r;
    end
  end
endmodule

// File: rtl/cffs_ftest.sv
module cffs_ftest
  import cffs_pkg::*;
(
  input  logic            en,
  input  cf_op_e          op,
  input  logic [CF_W-1:0] val,
  input  logic [1:0]      d_b,
  input  logic [1:0]      tsel,
  input  logic            inv,
  output logic            fail
);
  logic [1:0] tbit;
  logic       pass;

  always_comb begin
    tbit = (op == OP_MOVE) ? tsel : d_b;
    pass = val[tbit] ^ inv;
    fail = en & ~pass;
  end
endmodule

// File: rtl/cf_failfirst_seq.sv
module cf_failfirst_seq
  import cffs_pkg::*;
#(
  parameter int MAX_VL   = 64,
  parameter int FIELD_AW = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [$clog2(MAX_VL+1)-1:0] vlen,
  input  logic [1:0]          opsel,
  input  logic [FIELD_AW+1:0] dst_idx,
  input  logic [FIELD_AW+1:0] srca_idx,
  input  logic [FIELD_AW+1:0] srcb_idx,
  input  logic [MAX_VL-1:0]   pmask,
  input  logic                zero_en,
  input  logic                ones_fill,
  input  logic                ff_en,
  input  logic                rev_order,
  input  logic                len_incl,
  input  logic                test_inv,
  input  logic [1:0]          test_sel,
  output logic [FIELD_AW-1:0] rf_a_addr,
  output logic [FIELD_AW-1:0] rf_b_addr,
  output logic [FIELD_AW-1:0] rf_d_addr,
  input  logic [3:0]          rf_a_data,
  input  logic [3:0]          rf_b_data,
  input  logic [3:0]          rf_d_data,
  output logic                rf_we,
  output logic [FIELD_AW-1:0] rf_waddr,
  output logic [3:0]          rf_wdata,
  output logic                fin,
  output logic [$clog2(MAX_VL+1)-1:0] res_len
);
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int EIW = $clog2(MAX_VL);
  localparam int BAW = FIELD_AW + 2;

  // captured run parameters
  logic              run;
  logic [VLW-1:0]    c_vl;
  cf_op_e            c_op;
  logic [BAW-1:0]    c_dst, c_sa, c_sb;
  logic [MAX_VL-1:0] c_pm;
  logic              c_zero, c_ones, c_ff, c_rev, c_incl, c_inv;
  logic [1:0]        c_tsel;

  logic              launch;
  logic [VLW-1:0]    step, elem;
  logic              last;
  logic [FIELD_AW-1:0] eoff, a_fld, b_fld, d_fld;
  logic [3:0]        a_f, b_f, d_f, val;
  logic              pbit, wr, fail, finish;

  assign launch = go & ~run;

  cffs_order #(.MAX_VL(MAX_VL), .VLW(VLW)) u_order (
    .clk(clk), .rst(rst), .load(launch), .adv(run), .rev(c_rev),
    .vl(c_vl), .step(step), .elem(elem), .last(last)
  );

  // field addresses advance by one per element, bit position fixed
  assign eoff  = FIELD_AW'(elem);
  assign a_fld = c_sa[BAW-1:2]  + eoff;
  assign b_fld = c_sb[BAW-1:2]  + eoff;
  assign d_fld = c_dst[BAW-1:2] + eoff;
  assign rf_a_addr = a_fld;
  assign rf_b_addr = b_fld;
  assign rf_d_addr = d_fld;

  // bypass the write still held in the output register (one-deep hazard)
  assign a_f = (rf_we && rf_waddr == a_fld) ? rf_wdata : rf_a_data;
  assign b_f = (rf_we && rf_waddr == b_fld) ? rf_wdata : rf_b_data;
  assign d_f = (rf_we && rf_waddr == d_fld) ? rf_wdata : rf_d_data;

  assign pbit = c_pm[elem[EIW-1:0]];

  cffs_elem u_elem (
    .op(c_op), .pbit(pbit), .zero_en(c_zero), .ones_fill(c_ones),
    .a_f(a_f), .b_f(b_f), .d_f(d_f),
    .a_b(c_sa[1:0]), .b_b(c_sb[1:0]), .d_b(c_dst[1:0]),
    .wr(wr), .val(val)
  );

  cffs_ftest u_ftest (
    .en(c_ff & wr), .op(c_op), .val(val), .d_b(c_dst[1:0]),
    .tsel(c_tsel), .inv(c_inv), .fail(fail)
  );

  assign finish = run & (fail | last);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      fin      <= 1'b0;
      res_len  <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      c_vl     <= '0;
      c_op     <= OP_AND;
      c_dst    <= '0;
      c_sa     <= '0;
      c_sb     <= '0;
      c_pm     <= '0;
      c_zero   <= 1'b0;
      c_ones   <= 1'b0;
      c_ff     <= 1'b0;
      c_rev    <= 1'b0;
      c_incl   <= 1'b0;
      c_inv    <= 1'b0;
      c_tsel   <= '0;
    end else begin
      fin      <= 1'b0;
      rf_we    <= run & wr;
      rf_waddr <= d_fld;
      rf_wdata <= val;
      if (launch) begin
        c_vl   <= vlen;
        c_op   <= cf_op_e'(opsel);
        c_dst  <= dst_idx;
        c_sa   <= srca_idx;
        c_sb   <= srcb_idx;
        c_pm   <= pmask;
        c_zero <= zero_en;
        c_ones <= ones_fill;
        c_ff   <= ff_en;
        c_rev  <= rev_order;
        c_incl <= len_incl;
        c_inv  <= test_inv;
        c_tsel <= test_sel;
        if (vlen == '0) begin
          fin     <= 1'b1;
          res_len <= '0;
        end else begin
          run <= 1'b1;
        end
      end else if (finish) begin
        run     <= 1'b0;
        fin     <= 1'b1;
        res_len <= fail ? (step + VLW'(c_incl)) : c_vl;
      end
    end
  end

  // R6: a masked element without fill produces no write
  a_r6_skip_no_write: assert property (@(posedge clk) disable iff (rst)
    (run && !pbit && !c_zero) |=> !rf_we);

  // R7: nothing is written in the cycle after the done pulse
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    fin |=> !rf_we);

  // R8: reported length never exceeds the requested length
  a_r8_len_bounded: assert property (@(posedge clk) disable iff (rst)
    fin |-> (res_len <= c_vl));

  // R9: an empty vector finishes on the next edge with length zero
  a_r9_empty_immediate: assert property (@(posedge clk) disable iff (rst)
    (go && !run && vlen == '0) |=> (fin && res_len == '0));

  // R10: a start request during a run leaves the captured length alone
  a_r10_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (run && go) |=> $stable(c_vl));
endmodule

// File: tb/tb_cf_failfirst_seq.sv
`timescale 1ns/1ps
module tb_cf_failfirst_seq;
  localparam int NF = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [6:0]  vlen = '0;
  logic [1:0]  opsel = '0;
  logic [8:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0;
  logic [63:0] pmask = '0;
  logic        zero_en = 0, ones_fill = 0, ff_en = 0, rev_order = 0;
  logic        len_incl = 0, test_inv = 0;
  logic [1:0]  test_sel = '0;
  logic [6:0]  rf_a_addr, rf_b_addr, rf_d_addr, rf_waddr;
  logic [3:0]  rf_a_data, rf_b_data, rf_d_data, rf_wdata;
  logic        rf_we, fin;
  logic [6:0]  res_len;

  logic [3:0] mem [NF];
  logic [3:0] mdl [NF];

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [10:0] wq[$];
  string       wtag[$];
  logic [6:0]  lq[$];
  string       ltag[$];

  cf_failfirst_seq dut (
    .clk(clk), .rst(rst), .go(go), .vlen(vlen), .opsel(opsel),
    .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .pmask(pmask), .zero_en(zero_en), .ones_fill(ones_fill), .ff_en(ff_en),
    .rev_order(rev_order), .len_incl(len_incl), .test_inv(test_inv),
    .test_sel(test_sel), .rf_a_addr(rf_a_addr), .rf_b_addr(rf_b_addr),
    .rf_d_addr(rf_d_addr), .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .rf_d_data(rf_d_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .fin(fin), .res_len(res_len)
  );

  always #2 clk = ~clk;

  initial begin
    for (int i = 0; i < NF; i++) begin
      mem[i] = 4'((i * 5 + i / 3) % 16);
      mdl[i] = 4'((i * 5 + i / 3) % 16);
    end
  end

  assign rf_a_data = mem[rf_a_addr];
  assign rf_b_data = mem[rf_b_addr];
  assign rf_d_data = mem[rf_d_addr];

  always @(posedge clk) if (rf_we) mem[rf_waddr] <= rf_wdata;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cycles);
      fails = fails + 1;
      tests = tests + 1;
      report();
    end
  end

  // monitor: compares each write and each done pulse with the queues
  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we) begin
        tests = tests + 1;
        if (wq.size() == 0) begin
          fails = fails + 1;
          $display("FAIL R6/R7 unexpected write: actual addr=%0d data=%h expected none",
                   rf_waddr, rf_wdata);
        end else begin
          automatic logic [10:0] e = wq.pop_front();
          automatic string t = wtag.pop_front();
          if ({rf_waddr, rf_wdata} !== e) begin
            fails = fails + 1;
            $display("FAIL %s write: actual addr=%0d data=%h expected addr=%0d data=%h",
                     t, rf_waddr, rf_wdata, e[10:4], e[3:0]);
          end
        end
      end
      if (fin) begin
        tests = tests + 1;
        if (lq.size() == 0) begin
          fails = fails + 1;
          $display("FAIL R8/R10 unexpected done: actual len=%0d expected none", res_len);
        end else begin
          automatic logic [6:0] el = lq.pop_front();
          automatic string t = ltag.pop_front();
          if (res_len !== el || wq.size() != 0) begin
            fails = fails + 1;
            $display("FAIL %s length: actual len=%0d pending=%0d expected len=%0d pending=0",
                     t, res_len, wq.size(), el);
          end
        end
      end
    end
  end

  function automatic bit fn(int op, bit a, bit b);
    case (op)
      0: return a & b;
      1: return a | b;
      2: return !(a | b);
      default: return a;
    endcase
  endfunction

  // driver: predicts with its own model, queues the expectations, starts a run
  task automatic run_op(string tag, int vl, int op, int dst, int sa, int sb,
                        logic [63:0] pm, bit z, bit one, bit ff, bit rv,
                        bit inc, bit inv, int ts, bit glitch);
    int len = vl;
    for (int s = 0; s < vl; s++) begin
      automatic int e  = rv ? vl - 1 - s : s;
      automatic int fd = ((dst >> 2) + e) % NF;
      automatic int fa = ((sa >> 2) + e) % NF;
      automatic int fb = ((sb >> 2) + e) % NF;
      automatic logic [3:0] v = mdl[fd];
      automatic int tb;
      if (!pm[e]) begin
        if (!z) continue;
        v = one ? 4'hF : 4'h0;
      end else if (op == 3) begin
        v = mdl[fa];
      end else begin
        v[dst & 3] = fn(op, mdl[fa][sa & 3], mdl[fb][sb & 3]);
      end
      mdl[fd] = v;
      wq.push_back({7'(fd), v});
      wtag.push_back(tag);
      tb = (op == 3) ? ts : (dst & 3);
      if (ff && ((v[tb] ^ inv) == 1'b0)) begin
        len = s + int'(inc);
        break;
      end
    end
    lq.push_back(7'(len));
    ltag.push_back(tag);
    @(negedge clk);
    vlen = 7'(vl); opsel = 2'(op); dst_idx = 9'(dst); srca_idx = 9'(sa);
    srcb_idx = 9'(sb); pmask = pm; zero_en = z; ones_fill = one; ff_en = ff;
    rev_order = rv; len_incl = inc; test_inv = inv; test_sel = 2'(ts);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (glitch) begin
      vlen = 7'd0;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    while (!fin) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    tests = tests + 1;
    if (fin !== 1'b0 || rf_we !== 1'b0 || res_len !== 7'd0) begin
      fails = fails + 1;
      $display("FAIL R1 reset: actual fin=%b we=%b len=%0d expected 0 0 0",
               fin, rf_we, res_len);
    end
    rst = 1'b0;
    @(negedge clk);

    run_op("R2 R4 and fwd",   8, 0, 0*4+1, 20*4+2, 40*4+0, '1, 0,0,0,0,0,0,0, 0);
    run_op("R4 or",           5, 1, 60*4+3, 70*4+0, 80*4+1, '1, 0,0,0,0,0,0,0, 0);
    run_op("R4 nor",          5, 2, 90*4+2, 70*4+3, 20*4+2, '1, 0,0,0,0,0,0,0, 0);
    run_op("R4 move",         6, 3, 100*4, 30*4, 0, '1, 0,0,0,0,0,0,0, 0);
    run_op("R3 reverse move", 6, 3, 10*4, 50*4, 0, '1, 0,0,0,1,0,0,0, 0);
    run_op("R5 zero fill",    8, 0, 110*4+0, 20*4+1, 30*4+2, 64'hA5, 1,0,0,0,0,0,0, 0);
    run_op("R5 ones fill",    8, 3, 110*4, 60*4, 0, 64'h5A, 1,1,0,1,0,0,0, 0);
    run_op("R6 skip",         10, 1, 5*4+2, 75*4+0, 85*4+3, 64'h2D3, 0,0,1,0,1,1,0, 0);
    run_op("R7 R8 ff move excl", 12, 3, 40*4, 64*4, 0, '1, 0,0,1,0,0,0,2, 0);
    run_op("R7 R8 ff move incl", 12, 3, 40*4, 64*4, 0, '1, 0,0,1,0,1,0,2, 0);
    run_op("R7 R8 ff nor inv", 16, 2, 0*4+3, 30*4+1, 50*4+0, '1, 0,0,1,0,1,1,0, 0);
    run_op("R8 ff reverse",   12, 0, 70*4+1, 90*4+1, 100*4+2, '1, 0,0,1,1,1,0,0, 0);
    run_op("R8 ff reverse excl", 12, 3, 20*4, 44*4, 0, '1, 0,0,1,1,0,1,1, 0);
    run_op("R7 ff zero tested", 8, 0, 10*4+0, 60*4+0, 61*4+0, 64'hF0, 1,0,1,0,1,0,0, 0);
    run_op("R9 empty",        0, 0, 0, 0, 0, '1, 0,0,0,0,0,0,0, 0);
    run_op("R10 go ignored",  10, 1, 30*4+2, 50*4+1, 55*4+0, '1, 0,0,0,0,0,0,0, 1);
    run_op("R11 chain fwd",   10, 0, 5*4+2, 4*4+2, 80*4+1, '1, 0,0,0,0,0,0,0, 0);
    run_op("R11 chain rev",   10, 3, 4*4, 5*4, 0, '1, 0,0,0,1,0,0,0, 0);
    run_op("R2 full length",  64, 1, 0*4+0, 64*4+1, 32*4+2, '1, 0,0,0,0,0,0,0, 0);

    tests = tests + 1;
    if (wq.size() != 0 || lq.size() != 0) begin
      fails = fails + 1;
      $display("FAIL R8 leftover: actual writes=%0d lens=%0d expected 0 0",
               wq.size(), lq.size());
    end
    report();
  end
endmodule